// File: doc/BRIEF.md
# Oscillator Stabilization Wait Counter

This block holds off the rest of the system until two oscillators have been running long enough to be trusted. Each oscillator has its own enable and its own clock. Each also has a ready flag. When the enable goes high, a counter that runs on that oscillator's own clock counts a programmable number of its rising edges. It then raises that oscillator's internal ready flag. Each flag passes through a two-flop synchronizer before the system clock domain sees it.

The two wait lengths are set by an 8-bit configuration register on a byte-wide write port, and the register can be read back at any time. The high-speed oscillator takes a 2-bit code. Larger codes give shorter waits. The low-speed oscillator takes a 2-bit code with two legal values, and its other two codes fall back to the longest wait. After reset both codes are 0, which selects the longest wait for each oscillator.

The counter samples the wait code at the first oscillator edge after its enable rises. It ignores any later change until the next enable. All pins are plain control and status signals: there is no data stream and so no valid/ready handshake.

Top module: `osc_stab_wait`

## Requirements
- R1: A write with `cfg_wr` high at a rising `sys_clk` edge loads bits 7:6 (high-speed wait code) and bits 1:0 (low-speed wait code) of `cfg_wdata`. `cfg_rdata` shows the register with bits 5:2 always 0. Without `cfg_wr`, the register holds its value.
- R2: After reset, `cfg_rdata` is 0x00 and both ready outputs are 0.
- R3: The high-speed wait code selects a length in cycles: 0 gives 64, 1 gives 32, 2 gives 16 and 3 gives 8.
- R4: The low-speed wait code selects 16384 cycles for code 0 and 4096 cycles for code 2.
- R5: The low-speed codes 1 and 3 are reserved and select the 16384-cycle wait.
- R6: With its enable held high, an oscillator's internal ready flag sets on exactly the N-th rising edge of its clock after the enable rose, where N is the selected length. It stays set while the enable stays high.
- R7: Driving an enable low clears that oscillator's counter and ready flag at once, without waiting for a clock. The next enable starts a full wait again.
- R8: Each ready output is its internal flag after two `sys_clk` flops. It therefore follows the flag within three `sys_clk` rising edges. The two oscillators do not affect each other.
- R9: The counter captures the wait code at the first oscillator edge after its enable rises. A register write after that point has no effect on the wait in progress and applies from the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset for all state |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, bits 5:2 zero |
| hs_clk | input | 1 | High-speed oscillator clock |
| hs_en | input | 1 | High-speed oscillator enable |
| ls_clk | input | 1 | Low-speed oscillator clock |
| ls_en | input | 1 | Low-speed oscillator enable |
| hs_ready | output | 1 | High-speed stable flag, synchronized to `sys_clk` |
| ls_ready | output | 1 | Low-speed stable flag, synchronized to `sys_clk` |

## Verification
A register write shows on `cfg_rdata` after the `sys_clk` edge that takes it, so the bench reads back on the following falling edge.

The internal ready flag changes on the N-th oscillator edge, and it reaches the output after two `sys_clk` flops. For that reason, every ready check waits three full system cycles after the last oscillator pulse or enable change.

The bench drives each oscillator one pulse at a time. It samples the ready output after N-1 pulses, where it must still be low, and again after exactly N pulses, where it must be high. An off-by-one error in any wait length therefore shows up as a miscompare.

// File: rtl/osw_pkg.sv
package osw_pkg;
  localparam int NUM_OSC  = 2;
  localparam int OSC_HS   = 0;
  localparam int OSC_LS   = 1;
  localparam int CODE_W   = 2;
  localparam int REG_W    = 8;
  localparam int HS_MSB   = 7;
  localparam int LS_MSB   = 1;
endpackage

// File: rtl/osw_cfg_reg.sv
module osw_cfg_reg
  import osw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [CODE_W-1:0] hs_code,
  output logic [CODE_W-1:0] ls_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_code <= '0;
      ls_code <= '0;
    end else if (wr) begin
      hs_code <= wdata[HS_MSB -: CODE_W];
      ls_code <= wdata[LS_MSB -: CODE_W];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[HS_MSB -: CODE_W] = hs_code;
    rdata[LS_MSB -: CODE_W] = ls_code;
  end
endmodule

// File: rtl/osw_counter.sv
module osw_counter #(
  parameter int CNT_W = 15
) (
  input  logic             osc_clk,
  input  logic             arst_n,
  input  logic [CNT_W-1:0] limit_in,
  output logic             ready
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_q;
  logic             armed;
  logic [CNT_W-1:0] lim_eff;
  logic [CNT_W-1:0] cnt_nxt;

  assign lim_eff = armed ? lim_q : limit_in;
  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge osc_clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt   <= '0;
      lim_q <= '0;
      armed <= 1'b0;
      ready <= 1'b0;
    end else begin
      if (!armed) begin
        armed <= 1'b1;
        lim_q <= limit_in;
      end
      if (!ready) begin
        cnt <= cnt_nxt;
        if (cnt_nxt == lim_eff) ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/osw_sync.sv
module osw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/osc_stab_wait.sv
module osc_stab_wait
  import osw_pkg::*;
#(
  parameter int HS_SHORT_CYC = 8,
  parameter int LS_LONG_CYC  = 16384,
  parameter int LS_SHORT_CYC = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             hs_clk,
  input  logic             hs_en,
  input  logic             ls_clk,
  input  logic             ls_en,
  output logic             hs_ready,
  output logic             ls_ready
);
  localparam int HS_LONG_CYC = HS_SHORT_CYC << 3;
  localparam int MAX_CYC = (LS_LONG_CYC > HS_LONG_CYC) ? LS_LONG_CYC : HS_LONG_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic [CODE_W-1:0] hs_code, ls_code;
  logic [CNT_W-1:0]  limit_v [NUM_OSC];
  logic [NUM_OSC-1:0] clk_v, en_v, rdy_raw, rdy_sys;

  osw_cfg_reg u_reg (
    .clk     (sys_clk),
    .rst_n   (sys_rst_n),
    .wr      (cfg_wr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .hs_code (hs_code),
    .ls_code (ls_code)
  );

  always_comb begin
    limit_v[OSC_HS] = CNT_W'(HS_SHORT_CYC << (3 - int'(hs_code)));
    case (ls_code)
      2'd2:    limit_v[OSC_LS] = CNT_W'(LS_SHORT_CYC);
      default: limit_v[OSC_LS] = CNT_W'(LS_LONG_CYC);
    endcase
  end

  assign clk_v[OSC_HS] = hs_clk;
  assign clk_v[OSC_LS] = ls_clk;
  assign en_v[OSC_HS]  = hs_en;
  assign en_v[OSC_LS]  = ls_en;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    osw_counter #(.CNT_W(CNT_W)) u_cnt (
      .osc_clk  (clk_v[g]),
      .arst_n   (en_v[g] & sys_rst_n),
      .limit_in (limit_v[g]),
      .ready    (rdy_raw[g])
    );
    osw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (sys_clk),
      .rst_n (sys_rst_n),
      .d     (rdy_raw[g]),
      .q     (rdy_sys[g])
    );
  end

  assign hs_ready = rdy_sys[OSC_HS];
  assign ls_ready = rdy_sys[OSC_LS];
endmodule

// File: rtl/osw_checker.sv
module osw_checker (
  input logic       sys_clk,
  input logic       sys_rst_n,
  input logic       cfg_wr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       hs_en,
  input logic       ls_en,
  input logic       hs_ready,
  input logic       ls_ready
);
  // R1
  reserved_zero_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    cfg_rdata[5:2] == 4'b0);

  // R1
  write_load_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    cfg_wr |=> (cfg_rdata[7:6] == $past(cfg_wdata[7:6]) && cfg_rdata[1:0] == $past(cfg_wdata[1:0])));

  // R1
  reg_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !cfg_wr |=> $stable(cfg_rdata));

  // R7
  hs_drop_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (!hs_en && $past(!hs_en) && $past(!hs_en, 2)) |-> !hs_ready);

  // R7
  ls_drop_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (!ls_en && $past(!ls_en) && $past(!ls_en, 2)) |-> !ls_ready);
endmodule

bind osc_stab_wait osw_checker u_osw_checker (
  .sys_clk   (sys_clk),
  .sys_rst_n (sys_rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .hs_en     (hs_en),
  .ls_en     (ls_en),
  .hs_ready  (hs_ready),
  .ls_ready  (ls_ready)
);

// File: tb/osc_stab_wait_bench.sv
`timescale 1ns/1ps
module osc_stab_wait_bench;
  logic       sys_clk = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       hs_clk = 1'b0, hs_en = 1'b0;
  logic       ls_clk = 1'b0, ls_en = 1'b0;
  logic       hs_ready, ls_ready;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 sys_clk = ~sys_clk;

  osc_stab_wait u_osc_stab_wait (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hs_clk(hs_clk), .hs_en(hs_en), .ls_clk(ls_clk), .ls_en(ls_en),
    .hs_ready(hs_ready), .ls_ready(ls_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sys_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge sys_clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge sys_clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge sys_clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_hs(input int n);
    for (int i = 0; i < n; i++) begin
      #3 hs_clk = 1'b1; #3 hs_clk = 1'b0;
    end
  endtask

  task automatic pulse_ls(input int n);
    for (int i = 0; i < n; i++) begin
      #3 ls_clk = 1'b1; #3 ls_clk = 1'b0;
    end
  endtask

  function automatic int hs_len(input int code);
    return 64 >> code;
  endfunction

  function automatic int ls_len(input int code);
    return (code == 2) ? 4096 : 16384;
  endfunction

  initial begin
    sys_cycles(3);
    // R2 reset state
    check("R2 rdata", cfg_rdata, 8'h00);
    check("R2 hs_ready", hs_ready, 0);
    check("R2 ls_ready", ls_ready, 0);
    sys_rst_n = 1'b1;
    sys_cycles(2);

    // R1 field layout and reserved bits
    write_reg(8'hFF); check("R1 write FF", cfg_rdata, 8'hC3);
    write_reg(8'h3C); check("R1 write 3C", cfg_rdata, 8'h00);
    write_reg(8'h81); check("R1 write 81", cfg_rdata, 8'h81);
    @(negedge sys_clk); cfg_wdata = 8'hFF;
    sys_cycles(2);
    check("R1 hold without strobe", cfg_rdata, 8'h81);

    // R3 R6 R8 high-speed sweep
    for (int c = 0; c < 4; c++) begin
      write_reg(8'(c << 6));
      hs_en = 1'b1;
      pulse_hs(hs_len(c) - 1);
      sys_cycles(3);
      check($sformatf("R3 hs code %0d before N", c), hs_ready, 0);
      pulse_hs(1);
      sys_cycles(3);
      check($sformatf("R6 hs code %0d at N", c), hs_ready, 1);
      check("R8 ls untouched", ls_ready, 0);
      pulse_hs(5);
      sys_cycles(3);
      check("R6 hs held", hs_ready, 1);
      hs_en = 1'b0;
      sys_cycles(3);
      check("R7 hs cleared", hs_ready, 0);
    end

    // R4 R5 low-speed sweep
    for (int c = 0; c < 4; c++) begin
      write_reg(8'(c));
      ls_en = 1'b1;
      pulse_ls(ls_len(c) - 1);
      sys_cycles(3);
      check($sformatf("R4/R5 ls code %0d before N", c), ls_ready, 0);
      pulse_ls(1);
      sys_cycles(3);
      check($sformatf("R4/R5 ls code %0d at N", c), ls_ready, 1);
      check("R8 hs untouched", hs_ready, 0);
      ls_en = 1'b0;
      sys_cycles(3);
      check("R7 ls cleared", ls_ready, 0);
    end

    // R9 mid-count change, then R7 restart with new code
    write_reg(8'h00);
    hs_en = 1'b1;
    pulse_hs(5);
    write_reg(8'hC0);
    pulse_hs(58);
    sys_cycles(3);
    check("R9 hs keeps 64 at 63", hs_ready, 0);
    pulse_hs(1);
    sys_cycles(3);
    check("R9 hs ready at 64", hs_ready, 1);
    hs_en = 1'b0;
    sys_cycles(3);
    hs_en = 1'b1;
    pulse_hs(7);
    sys_cycles(3);
    check("R7 restart full wait at 7", hs_ready, 0);
    pulse_hs(1);
    sys_cycles(3);
    check("R9 new code 8 at next enable", hs_ready, 1);
    // R7 disable mid-count then full restart
    hs_en = 1'b0;
    write_reg(8'h40);
    hs_en = 1'b1;
    pulse_hs(20);
    hs_en = 1'b0;
    sys_cycles(1);
    hs_en = 1'b1;
    pulse_hs(31);
    sys_cycles(3);
    check("R7 restart after abort at 31", hs_ready, 0);
    pulse_hs(1);
    sys_cycles(3);
    check("R7 restart after abort at 32", hs_ready, 1);
    hs_en = 1'b0;
    sys_cycles(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule